// File: doc/BRIEF.md
# I2C Target Register File with Change Alerts

This block is the digital side of an I2C target that exposes a small byte-wide register space. A host addresses it with a 7-bit device address whose top four bits are fixed and whose bottom three bits are taken from strap pins, captured once just after reset. After the address, a write transfer carries a register pointer and then data bytes. A read transfer returns bytes starting at the current pointer, which advances after every byte.

Three groups of status inputs (connection, monitoring and fault) come from the core. For each group the block keeps a sticky change register: a bit sets whenever the matching status bit toggles, and the bit clears when the host reads it. A derived summary register shows which groups have pending changes. An enable register selects which groups can drive the interrupt output. SCL and SDA pass through a two-stage synchronizer and a short majority-free glitch filter before any edge or bus condition is decoded. The open-drain pad itself is outside; the block only asks for SDA to be pulled low.

Top module: `i2c_alert_regs`

## Requirements
- R1: The block acknowledges only the device address {0101, strap[2:0]}, where the strap value is captured on the first clock after reset is released; later changes of the strap pins have no effect, and any other address is not acknowledged (SDA stays released during the acknowledge clock).
- R2: A write transfer is device address with R/W=0, one pointer byte, then data bytes, all MSB first; the pointer advances by one after every data byte written or read and wraps from 0xFF to 0x00.
- R3: Register layout: 0x00 summary (read-only, bit0 connection, bit1 monitoring, bit2 fault, each set while that group's change register is non-zero); 0x01 interrupt enable (read/write, bits 2:0 in the same group order, bits 7:3 read 0, reset 0); 0x02/0x04/0x06 change registers for connection/monitoring/fault (read-and-clear); 0x03/0x05/0x07 the live connection/monitoring/fault status.
- R4: Addresses 0x08 to 0xFF read 0x00 and ignore writes; writes to read-only and read-and-clear registers are ignored.
- R5: A change-register bit sets when its status bit differs between two consecutive clocks (the first clock after reset does not count) and stays set until it is read.
- R6: Reading a change register clears exactly the bits it returned; a status change in the clearing cycle remains set and is returned by a later read.
- R7: The interrupt output is high exactly when some group has a non-zero change register and its enable bit is set.
- R8: Pulses on SCL or SDA shorter than FILT clocks (after synchronization) do not disturb a transfer.
- R9: Read data leaves MSB first; a host ACK continues with the next register and a host NACK ends the read with SDA released.
- R10: During and right after reset, SDA is released, the interrupt is low, the enable register is 0 and all change registers are 0.
- R11: The block changes its SDA pull-down only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL level from the pad |
| sda_i | input | 1 | SDA level from the pad |
| addr_pins | input | 3 | Strap value for address bits 2:0 |
| conn_stat | input | 8 | Connection status from the core |
| mon_stat | input | 8 | Monitoring status from the core |
| flt_stat | input | 8 | Fault status from the core |
| sda_oe | output | 1 | 1 pulls SDA low |
| irq | output | 1 | Interrupt, active high |

## Verification
The bench uses the default parameters: the fixed address nibble 0101 and a filter of three clocks, with a quarter SCL period of eight clocks. With these values the filter and edge latency is shorter than a quarter period, so sweeping a status toggle across every cycle of the SCL low phase that follows a host ACK lands one toggle in the exact cycle the next change register is loaded and cleared. Two-clock pulses on both lines sit just below the filter length and check that short pulses are rejected.

// File: rtl/i2c_alert_regs.sv
module i2c_alert_regs #(
  parameter logic [3:0] DEV_HI = 4'b0101,
  parameter int         FILT   = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] addr_pins,
  input  logic [7:0] conn_stat,
  input  logic [7:0] mon_stat,
  input  logic [7:0] flt_stat,
  output logic       sda_oe,
  output logic       irq
);

  typedef enum logic [2:0] {S_IDLE, S_DEV, S_PTR, S_WR, S_RD} st_t;

  st_t             st;
  logic [1:0]      scl_s, sda_s;
  logic [FILT-1:0] scl_w, sda_w;
  logic            scl_f, sda_f, scl_d, sda_d;
  logic [7:0]      sh, ptr, rdat;
  logic [3:0]      bits;
  logic            ack, rw, mack, primed, load;
  logic [2:0]      pins_q, mask, summ;
  logic [1:0]      gidx;
  logic [2:0][7:0] stat;
  logic [7:0]      cq  [3];
  logic [7:0]      tr  [3];
  logic [7:0]      clr [3];

  assign stat = {flt_stat, mon_stat, conn_stat};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_s <= '1; sda_s <= '1; scl_w <= '1; sda_w <= '1;
      scl_f <= 1'b1; sda_f <= 1'b1; scl_d <= 1'b1; sda_d <= 1'b1;
    end else begin
      scl_s <= {scl_s[0], scl_i};
      sda_s <= {sda_s[0], sda_i};
      scl_w <= {scl_w[FILT-2:0], scl_s[1]};
      sda_w <= {sda_w[FILT-2:0], sda_s[1]};
      if (&scl_w) scl_f <= 1'b1; else if (~|scl_w) scl_f <= 1'b0;
      if (&sda_w) sda_f <= 1'b1; else if (~|sda_w) sda_f <= 1'b0;
      scl_d <= scl_f;
      sda_d <= sda_f;
    end
  end

  wire scl_rise = scl_f & ~scl_d;
  wire scl_fall = ~scl_f & scl_d;
  wire start_c  = scl_f & scl_d & sda_d & ~sda_f;
  wire stop_c   = scl_f & scl_d & ~sda_d & sda_f;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      primed <= 1'b0;
      pins_q <= '0;
    end else if (!primed) begin
      primed <= 1'b1;
      pins_q <= addr_pins;
    end
  end

  for (genvar i = 0; i < 3; i++) begin : g_grp
    assign summ[i] = |tr[i];
    assign clr[i]  = (load && ptr == 8'(2*i+2)) ? tr[i] : 8'h00;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cq[i] <= '0;
        tr[i] <= '0;
      end else begin
        cq[i] <= stat[i];
        tr[i] <= (tr[i] & ~clr[i]) | (primed ? (stat[i] ^ cq[i]) : 8'h00);
      end
    end
  end

  assign gidx = ptr[2:1] - 2'd1;

  always_comb begin
    rdat = 8'h00;
    if (ptr == 8'h00)      rdat = {5'b0, summ};
    else if (ptr == 8'h01) rdat = {5'b0, mask};
    else if (ptr <= 8'h07) rdat = ptr[0] ? stat[gidx] : tr[gidx];
  end

  assign load = scl_fall & ack & (((st == S_DEV) & rw) | ((st == S_RD) & mack));
  assign irq  = |(summ & mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; sh <= '0; ptr <= '0; bits <= '0;
      ack <= 1'b0; rw <= 1'b0; mack <= 1'b0; mask <= '0; sda_oe <= 1'b0;
    end else if (start_c) begin
      st <= S_DEV; bits <= '0; ack <= 1'b0; sda_oe <= 1'b0;
    end else if (stop_c) begin
      st <= S_IDLE; ack <= 1'b0; sda_oe <= 1'b0;
    end else begin
      case (st)
        S_IDLE: ;
        S_RD: begin
          if (scl_rise) begin
            if (ack) mack <= ~sda_f;
            else     bits <= bits + 4'd1;
          end
          if (scl_fall) begin
            if (ack) begin
              ack <= 1'b0;
              if (load) begin
                sh <= rdat; ptr <= ptr + 8'd1; bits <= '0; sda_oe <= ~rdat[7];
              end else begin
                st <= S_IDLE; sda_oe <= 1'b0;
              end
            end else if (bits == 4'd8) begin
              ack <= 1'b1; sda_oe <= 1'b0;
            end else begin
              sh <= {sh[6:0], 1'b0}; sda_oe <= ~sh[6];
            end
          end
        end
        default: begin
          if (scl_rise && !ack) begin
            sh   <= {sh[6:0], sda_f};
            bits <= bits + 4'd1;
          end
          if (scl_fall) begin
            if (ack) begin
              ack <= 1'b0; sda_oe <= 1'b0; bits <= '0;
              if (st == S_DEV && rw) begin
                st <= S_RD; sh <= rdat; ptr <= ptr + 8'd1; sda_oe <= ~rdat[7];
              end else if (st == S_DEV) st <= S_PTR;
              else st <= S_WR;
            end else if (bits == 4'd8) begin
              if (st == S_DEV) begin
                if (sh[7:1] == {DEV_HI, pins_q}) begin
                  ack <= 1'b1; sda_oe <= 1'b1; rw <= sh[0];
                end else st <= S_IDLE;
              end else begin
                ack <= 1'b1; sda_oe <= 1'b1;
                if (st == S_PTR) ptr <= sh;
                else begin
                  if (ptr == 8'h01) mask <= sh[2:0];
                  ptr <= ptr + 8'd1;
                end
              end
            end
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/i2c_alert_regs_chk.sv
module i2c_alert_regs_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        scl_i,
  input logic        sda_oe,
  input logic        irq,
  input logic [2:0]  mask,
  input logic [23:0] trans,
  input logic [23:0] stat,
  input logic        load,
  input logic        primed,
  input logic [2:0]  pins_q
);

  logic [23:0] sp;
  always_ff @(posedge clk) sp <= stat;

  a_r10_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!sda_oe && !irq && mask == 3'b000 && trans == 24'h0));

  a_r1_strap_held: assert property (@(posedge clk) disable iff (!rst_n)
    $past(primed) |-> $stable(pins_q));

  a_r5_change_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && stat != sp) |=> ((trans & $past(stat ^ sp)) == $past(stat ^ sp)));

  a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(primed) && !$past(load)) |-> ((trans & $past(trans)) == $past(trans)));

  a_r7_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (mask != 3'b000));

  a_r7_irq_needs_pending: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (trans != 24'h0));

  a_r11_sda_when_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |-> !scl_i);

endmodule

bind i2c_alert_regs i2c_alert_regs_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe(sda_oe), .irq(irq),
  .mask(mask), .trans({tr[2], tr[1], tr[0]}), .stat(stat), .load(load),
  .primed(primed), .pins_q(pins_q)
);

// File: tb/sim_i2c_alert_regs.sv
module sim_i2c_alert_regs;
  localparam int Q = 8;
  localparam logic [6:0] DADR = 7'h2D;
  localparam logic [23:0] VEC [0:8] = '{
    24'h01FF07, 24'h010202, 24'h08A500, 24'h7F3C00, 24'hFF8100,
    24'h000700, 24'h035500, 24'h026600, 24'h01AA02
  };

  logic clk = 1'b0, rst_n = 1'b0, m_scl = 1'b1, m_sda = 1'b1, glitch = 1'b0, done = 1'b0;
  logic [2:0] pins = 3'b101;
  logic [7:0] conn = 8'h00, mon = 8'h00, flt = 8'h00;
  logic sda_oe, irq;
  wire sda_line = m_sda & ~sda_oe;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  i2c_alert_regs u0 (.clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line),
    .addr_pins(pins), .conn_stat(conn), .mon_stat(mon), .flt_stat(flt),
    .sda_oe(sda_oe), .irq(irq));

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic hc(input int n); repeat (n) @(negedge clk); endtask

  task automatic i_start;
    m_sda = 1'b1; hc(Q); m_scl = 1'b1; hc(Q); m_sda = 1'b0; hc(Q); m_scl = 1'b0; hc(Q);
  endtask

  task automatic i_stop;
    m_sda = 1'b0; hc(Q); m_scl = 1'b1; hc(Q); m_sda = 1'b1; hc(2*Q);
  endtask

  task automatic bit_w(input logic b);
    if (glitch) begin hc(2); m_scl = 1'b1; hc(2); m_scl = 1'b0; hc(2); end
    m_sda = b; hc(Q); m_scl = 1'b1;
    if (glitch && b) begin hc(Q); m_sda = 1'b0; hc(2); m_sda = 1'b1; hc(Q-2); end
    else hc(2*Q);
    m_scl = 1'b0; hc(Q);
  endtask

  task automatic bit_r(output logic b);
    m_sda = 1'b1; hc(Q); m_scl = 1'b1; hc(Q); b = sda_line; hc(Q); m_scl = 1'b0; hc(Q);
  endtask

  task automatic wbyte(input logic [7:0] d, output logic nak);
    for (int i = 7; i >= 0; i--) bit_w(d[i]);
    bit_r(nak);
  endtask

  task automatic rbyte(output logic [7:0] d, input logic nack, input int hitk);
    logic b;
    for (int i = 7; i >= 0; i--) begin bit_r(b); d[i] = b; end
    m_sda = nack; hc(Q); m_scl = 1'b1; hc(2*Q); m_scl = 1'b0;
    for (int j = 0; j < Q; j++) begin
      if (j == hitk) flt[0] = ~flt[0];
      hc(1);
    end
  endtask

  task automatic reg_wr(input logic [7:0] p, input logic [7:0] d);
    logic a;
    i_start; wbyte({DADR, 1'b0}, a); wbyte(p, a); wbyte(d, a); i_stop;
  endtask

  task automatic rd_open(input logic [7:0] p);
    logic a;
    i_start; wbyte({DADR, 1'b0}, a); wbyte(p, a); i_start; wbyte({DADR, 1'b1}, a);
  endtask

  task automatic reg_rd(input logic [7:0] p, output logic [7:0] d);
    rd_open(p); rbyte(d, 1'b1, -1); i_stop;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] d, d0, d1, d2;
    logic a;
    logic [7:0] mb [6];
    hc(10); rst_n = 1'b1; hc(5);
    pins = 3'b010;

    chk("R10 sda released", {7'b0, sda_oe}, 8'h00);
    chk("R10 irq low", {7'b0, irq}, 8'h00);
    reg_rd(8'h01, d); chk("R10 enable reset", d, 8'h00);
    reg_rd(8'h02, d); chk("R10 change reset", d, 8'h00);

    // R3 R4 table: pointer, write value, expected readback
    foreach (VEC[k]) begin
      reg_wr(VEC[k][23:16], VEC[k][15:8]);
      reg_rd(VEC[k][23:16], d);
      chk($sformatf("R3/R4 vec%0d", k), d, VEC[k][7:0]);
      if (k == 7) begin reg_rd(8'h01, d); chk("R4 enable untouched", d, 8'h02); end
    end
    reg_wr(8'h01, 8'h00);

    i_start; wbyte(8'h54, a); i_stop; chk("R1 nack new strap", {7'b0, a}, 8'h01);
    i_start; wbyte(8'hDA, a); i_stop; chk("R1 nack top bits", {7'b0, a}, 8'h01);
    i_start; wbyte({DADR, 1'b0}, a); i_stop; chk("R1 ack latched", {7'b0, a}, 8'h00);

    conn = 8'h3C; hc(4);
    reg_rd(8'h03, d); chk("R3 live status", d, 8'h3C);
    reg_rd(8'h02, d); chk("R5 change seen", d, 8'h3C);
    reg_rd(8'h02, d); chk("R6 cleared", d, 8'h00);

    mon = 8'h81; hc(4);
    chk("R7 irq disabled", {7'b0, irq}, 8'h00);
    reg_rd(8'h00, d); chk("R3 summary", d, 8'h02);
    reg_wr(8'h01, 8'h05); hc(2); chk("R7 other groups", {7'b0, irq}, 8'h00);
    reg_wr(8'h01, 8'h02); hc(2); chk("R7 irq raised", {7'b0, irq}, 8'h01);
    reg_rd(8'h04, d); chk("R5 mon change", d, 8'h81);
    hc(2); chk("R7 irq dropped", {7'b0, irq}, 8'h00);

    flt = 8'h0F; conn = 8'h3D; hc(4);
    rd_open(8'h02);
    for (int i = 0; i < 6; i++) rbyte(mb[i], (i == 5), -1);
    i_stop;
    chk("R9 byte0", mb[0], 8'h01); chk("R2 byte1", mb[1], 8'h3D);
    chk("R2 byte2", mb[2], 8'h00); chk("R2 byte3", mb[3], 8'h81);
    chk("R9 byte4", mb[4], 8'h0F); chk("R2 byte5", mb[5], 8'h0F);
    chk("R9 sda released", {7'b0, sda_oe}, 8'h00);

    i_start; wbyte({DADR, 1'b0}, a); wbyte(8'hFF, a);
    wbyte(8'hAA, a); wbyte(8'h06, a); wbyte(8'h03, a); i_stop;
    reg_rd(8'h01, d); chk("R2 write wrap", d, 8'h03);
    reg_wr(8'h01, 8'h00);

    for (int k = 0; k < Q; k++) begin
      rd_open(8'h05); rbyte(d0, 1'b0, k); rbyte(d1, 1'b1, -1); i_stop;
      reg_rd(8'h06, d2);
      chk($sformatf("R6 same-cycle k=%0d", k), {7'b0, d1[0] ^ d2[0]}, 8'h01);
    end

    i_start; wbyte({DADR, 1'b0}, a); wbyte(8'h01, a);
    glitch = 1'b1; wbyte(8'h04, a); glitch = 1'b0; i_stop;
    reg_rd(8'h01, d); chk("R8 spikes ignored", d, 8'h04);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule